// File: doc/BRIEF.md
# Configurable Up/Down Timer with Quadrature Decoding

This block is a 16-bit event counter whose behaviour is set by one 8-bit control byte. The byte says whether the counter runs, where its count events come from, where its direction comes from, and how many events make up one count. Events can come from an internal base tick, which is the system clock divided by four. They can also come from both edges of an external clock pin, or from the valid phase changes of a two-channel incremental encoder wired to the clock and direction pins. Direction comes from a control bit, from the external direction pin, or, in encoder mode, from the phase order.

Both external pins are brought into the system clock domain through a two-stage synchronizer. A change detector follows the synchronizer. The encoder decoder is a four-state machine that tracks the last settled phase pair {A,B}: QP_00, QP_10, QP_11 and QP_01. It moves to the phase seen on the synchronized pins on every clock. The steps QP_00→QP_10→QP_11→QP_01→QP_00 count up, and the reverse steps count down. A move between two states that differ in both bits (QP_00↔QP_11, QP_10↔QP_01) gives no count. Software writes the control byte through a one-cycle write strobe and can read it back at any time. Each write restarts the internal dividers.

Top module: `updown_timer_top`

## Requirements
- R1: After reset the control byte reads 0x00 and count_out is 0x0000. The counter stays at zero until the control byte is written with bit 7 set.
- R2: A cycle with ctl_wr_en high loads ctl_wr_data into the control byte, and ctl_rd_data shows the new value from the next cycle on.
- R3: While control bit 7 is 0, count_out holds its value without being cleared. Setting the bit again resumes counting from that value.
- R4: In the internal-source modes (bits 5:3 = 000 or 010), one base tick occurs every 4 system clocks. With prescaler code 000, the first count change after a write comes on the 4th rising edge after the write edge.
- R5: The prescaler code N in bits 2:0 (0 to 6) makes one count out of every 2^N events, from either the internal base tick or the external clock. A control write restarts both the base divider and the prescaler from zero.
- R6: In modes 000, 001 and 101, control bit 6 = 1 counts up and 0 counts down.
- R7: In modes 001, 101 and 011, every rising and every falling change of ext_clk_in is one event. The resulting count change appears on the 3rd rising edge after the pin changes.
- R8: In modes 010 and 011, the synchronized ext_dir_in sets the direction (1 up, 0 down) and control bit 6 is ignored.
- R9: In mode 111 the pins form the phase pair {A = ext_clk_in, B = ext_dir_in}. Each single-bit change counts ±1 in the order given above. A change of both bits at once counts nothing, and the prescaler code is not applied.
- R10: Mode codes 100 and 110, and prescaler code 111, hold the counter in every case.
- R11: The counter wraps modulo 2^16: one step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R12: count_out never changes by more than one step in a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte write value |
| ctl_rd_data | output | 8 | Current control byte |
| ext_clk_in | input | 1 | External clock pin, or phase A in encoder mode |
| ext_dir_in | input | 1 | External direction pin, or phase B in encoder mode |
| count_out | output | 16 | Counter value |

## Verification
The hardest case to reach from the ports is the divider restart: its effect only shows when a second write lands partway through a long prescaled period. The bench rewrites the same control value 28 clocks into a 32-clock period. It then checks that no count appears where the old phase would have produced one, and that a count does appear a full period after the rewrite. The ignored double transition in encoder mode is the other awkward case. The bench changes both pins on the same falling edge, so that they enter the synchronizer together, and confirms that the count does not move.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // Where count events come from for the current mode code
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_QUAD = 2'd3
    } src_e;

    // Encoder phase pair {A,B}; the encoding is the pin pair itself
    typedef enum logic [1:0] {
        QP_00 = 2'b00,
        QP_01 = 2'b01,
        QP_10 = 2'b10,
        QP_11 = 2'b11
    } qphase_e;

    typedef struct packed {
        src_e src;
        logic dir_pin;
    } mode_dec_t;

    localparam int CTL_W       = 8;
    localparam int CTL_RUN_BIT = 7;
    localparam int CTL_UP_BIT  = 6;
    localparam int MODE_MSB    = 5;
    localparam int MODE_LSB    = 3;
    localparam int PS_MSB      = 2;
    localparam int PS_LSB      = 0;
    localparam int PS_CODE_W   = PS_MSB - PS_LSB + 1;
    localparam logic [PS_CODE_W-1:0] PS_RESERVED = '1;

    function automatic mode_dec_t decode_mode(input logic [2:0] m);
        mode_dec_t d;
        d.src     = SRC_HOLD;
        d.dir_pin = 1'b0;
        case (m)
            3'b000:         d.src = SRC_INT;
            3'b001, 3'b101: d.src = SRC_EXT;
            3'b010: begin
                d.src     = SRC_INT;
                d.dir_pin = 1'b1;
            end
            3'b011: begin
                d.src     = SRC_EXT;
                d.dir_pin = 1'b1;
            end
            3'b111:         d.src = SRC_QUAD;
            default:        d.src = SRC_HOLD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tmr_in_sync.sv
`timescale 1ns/1ps
module tmr_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic toggled
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain;
    logic         last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
        end
    end

    generate
        for (genvar g = 1; g < N; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last <= 1'b0;
        end else begin
            last <= chain[N-1];
        end
    end

    assign level   = chain[N-1];
    assign toggled = chain[N-1] ^ last;

endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
    parameter int BASE_DIV   = 4,
    parameter int PS_CODE_W  = 3,
    parameter int PS_MAX_EXP = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 run,
    input  logic                 use_ext,
    input  logic                 ext_evt,
    input  logic [PS_CODE_W-1:0] ps_code,
    output logic                 advance
);
    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int PW = (PS_MAX_EXP > 0) ? PS_MAX_EXP : 1;
    localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);

    logic [BW-1:0] base_cnt;
    logic          base_tick;
    logic [PW-1:0] ps_cnt;
    logic [PW-1:0] ps_mask;
    logic          evt;
    logic          ps_wrap;

    assign base_tick = run && !use_ext && (base_cnt == BASE_LAST);
    assign evt       = run && (use_ext ? ext_evt : base_tick);

    always_comb begin
        ps_mask = '0;
        for (int i = 0; i < PW; i++) begin
            if (i < int'(ps_code)) begin
                ps_mask[i] = 1'b1;
            end
        end
    end

    assign ps_wrap = (ps_cnt >= ps_mask);
    assign advance = evt && ps_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt <= '0;
        end else if (clr) begin
            base_cnt <= '0;
        end else if (run && !use_ext) begin
            base_cnt <= base_tick ? '0 : base_cnt + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_cnt <= '0;
        end else if (clr) begin
            ps_cnt <= '0;
        end else if (evt) begin
            ps_cnt <= ps_wrap ? '0 : ps_cnt + PW'(1);
        end
    end

endmodule

// File: rtl/tmr_quad_fsm.sv
`timescale 1ns/1ps
module tmr_quad_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    output logic step_up,
    output logic step_dn
);
    qphase_e cur_ph;
    qphase_e nxt_ph;

    assign nxt_ph = qphase_e'({pin_a, pin_b});

    // State register: always follows the settled pin pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ph <= QP_00;
        end else begin
            cur_ph <= nxt_ph;
        end
    end

    // Outputs: single-bit moves step, double-bit moves give nothing
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (cur_ph)
            QP_00: begin
                step_up = (nxt_ph == QP_10);
                step_dn = (nxt_ph == QP_01);
            end
            QP_10: begin
                step_up = (nxt_ph == QP_11);
                step_dn = (nxt_ph == QP_00);
            end
            QP_11: begin
                step_up = (nxt_ph == QP_01);
                step_dn = (nxt_ph == QP_10);
            end
            QP_01: begin
                step_up = (nxt_ph == QP_00);
                step_dn = (nxt_ph == QP_11);
            end
        endcase
    end

endmodule

// File: rtl/updown_timer_top.sv
`timescale 1ns/1ps
module updown_timer_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BASE_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PS_MAX_EXP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [7:0]       ctl_wr_data,
    output logic [7:0]       ctl_rd_data,
    input  logic             ext_clk_in,
    input  logic             ext_dir_in,
    output logic [CNT_W-1:0] count_out
);
    logic [CTL_W-1:0]     ctl_q;
    mode_dec_t            mdec;
    logic [PS_CODE_W-1:0] ps_code;
    logic                 active;
    logic                 clk_lvl, clk_tog;
    logic                 dir_lvl, dir_tog;
    logic                 q_up, q_dn;
    logic                 advance;
    logic                 dir_up;
    logic [CNT_W-1:0]     count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr_en) begin
            ctl_q <= ctl_wr_data;
        end
    end

    assign mdec    = decode_mode(ctl_q[MODE_MSB:MODE_LSB]);
    assign ps_code = ctl_q[PS_MSB:PS_LSB];
    assign active  = ctl_q[CTL_RUN_BIT] && (ps_code != PS_RESERVED)
                     && (mdec.src != SRC_HOLD);
    assign dir_up  = mdec.dir_pin ? dir_lvl : ctl_q[CTL_UP_BIT];

    tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ext_clk_in),
        .level   (clk_lvl),
        .toggled (clk_tog)
    );

    tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ext_dir_in),
        .level   (dir_lvl),
        .toggled (dir_tog)
    );

    tmr_tick_gen #(
        .BASE_DIV  (BASE_DIV),
        .PS_CODE_W (PS_CODE_W),
        .PS_MAX_EXP(PS_MAX_EXP)
    ) u_ticks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctl_wr_en),
        .run    (active && (mdec.src == SRC_INT || mdec.src == SRC_EXT)),
        .use_ext(mdec.src == SRC_EXT),
        .ext_evt(clk_tog),
        .ps_code(ps_code),
        .advance(advance)
    );

    tmr_quad_fsm u_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_a  (clk_lvl),
        .pin_b  (dir_lvl),
        .step_up(q_up),
        .step_dn(q_dn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (active) begin
            if (mdec.src == SRC_QUAD) begin
                if (q_up) begin
                    count_q <= count_q + CNT_W'(1);
                end else if (q_dn) begin
                    count_q <= count_q - CNT_W'(1);
                end
            end else if (advance) begin
                count_q <= dir_up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
            end
        end
    end

    // The direction pin's change flag has no use: the level alone steers
    logic unused_dir_tog;
    assign unused_dir_tog = dir_tog;

    assign ctl_rd_data = ctl_q;
    assign count_out   = count_q;

endmodule

// File: rtl/tmr_checks.sv
`timescale 1ns/1ps
module tmr_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr_en,
    input logic [7:0]       ctl_wr_data,
    input logic [7:0]       ctl_rd_data,
    input logic [CNT_W-1:0] count_out
);
    // R1: registers come out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_rd_data == 8'h00 && count_out == '0));

    // R2: written byte is visible the next cycle
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (ctl_rd_data == $past(ctl_wr_data)));

    // R3: stopped timer keeps its value
    a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd_data[7] |=> (count_out == $past(count_out)));

    // R10: reserved mode or prescaler codes hold the counter
    a_r10_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_data[5:3] == 3'b100 || ctl_rd_data[5:3] == 3'b110 ||
         ctl_rd_data[2:0] == 3'b111) |=> $stable(count_out));

    // R12: at most one step per cycle, wrapping included (R11)
    a_r12_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out != $past(count_out)) |->
        (count_out == $past(count_out) + CNT_W'(1) ||
         count_out == $past(count_out) - CNT_W'(1)));

endmodule

bind updown_timer_top tmr_checks #(.CNT_W(CNT_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data),
    .count_out  (count_out)
);

// File: tb/sim_updown_timer_top.sv
`timescale 1ns/1ps
module sim_updown_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [7:0]  ctl_wr_data = 8'h00;
    logic [7:0]  ctl_rd_data;
    logic        ext_clk_in = 1'b0;
    logic        ext_dir_in = 1'b0;
    logic [15:0] count_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_cnt = 16'h0000;

    always #2 clk = ~clk;

    updown_timer_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_en  (ctl_wr_en),
        .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data),
        .ext_clk_in (ext_clk_in),
        .ext_dir_in (ext_dir_in),
        .count_out  (count_out)
    );

    // {control byte, cycles to run, expected count delta}
    localparam logic [39:0] VEC [10] = '{
        {8'h80, 16'd40,  16'hFFF6},  // R6 down, R4 base rate, R11 wrap below zero
        {8'h40, 16'd40,  16'h0000},  // R3 stopped, value kept
        {8'hC0, 16'd40,  16'h000A},  // R6 up, R11 wrap past 0xFFFF
        {8'hC1, 16'd40,  16'h0005},  // R5 divide by 2
        {8'hC2, 16'd48,  16'h0003},  // R5 divide by 4
        {8'hC6, 16'd256, 16'h0001},  // R5 divide by 64
        {8'hE0, 16'd40,  16'h0000},  // R10 mode 100
        {8'hF0, 16'd40,  16'h0000},  // R10 mode 110
        {8'hC7, 16'd40,  16'h0000},  // R10 prescaler 111
        {8'hD0, 16'd40,  16'hFFF6}   // R8 pin low overrides bit 6
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic write_ctl(input logic [7:0] v);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = v;
        @(posedge clk);
        @(negedge clk);
        ctl_wr_en = 1'b0;
        check("R2 readback", int'(ctl_rd_data), int'(v));
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ext_toggle(input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk_in = ~ext_clk_in;
            run_cycles(4);
        end
    endtask

    task automatic quad_move(input logic a, input logic b);
        ext_clk_in = a;
        ext_dir_in = b;
        run_cycles(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctl reset", int'(ctl_rd_data), 0);
        check("R1 count reset", int'(count_out), 0);
        run_cycles(20);
        check("R1 idle after reset", int'(count_out), 0);

        // Vector table
        for (int i = 0; i < 10; i++) begin
            logic [7:0]  c = VEC[i][39:32];
            int          cyc = int'(VEC[i][31:16]);
            logic [15:0] d = VEC[i][15:0];
            write_ctl(c);
            run_cycles(cyc);
            exp_cnt = exp_cnt + d;
            check($sformatf("R4/R5/R6/R8/R10/R11 vector %0d", i),
                  int'(count_out), int'(exp_cnt));
        end

        // R4 / R12: first step lands on the 4th edge after the write
        write_ctl(8'hC0);
        run_cycles(3);
        check("R4 no step before 4th edge", int'(count_out), int'(exp_cnt));
        run_cycles(1);
        check("R12 single step on 4th edge", int'(count_out), int'(exp_cnt + 16'd1));
        exp_cnt = exp_cnt + 16'd1;
        run_cycles(3);
        check("R12 no further step yet", int'(count_out), int'(exp_cnt));
        run_cycles(1);

        // R5: rewrite restarts the 32-clock period
        write_ctl(8'hC3);
        exp_cnt = count_out;
        run_cycles(28);
        write_ctl(8'hC3);
        run_cycles(28);
        check("R5 restart suppresses old phase", int'(count_out), int'(exp_cnt));
        run_cycles(4);
        check("R5 count after full period", int'(count_out), int'(exp_cnt + 16'd1));
        exp_cnt = exp_cnt + 16'd1;

        // R7: external clock, both edges
        write_ctl(8'hC8);
        exp_cnt = count_out;
        ext_toggle(6);
        check("R7 mode 001 up both edges", int'(count_out), int'(exp_cnt + 16'd6));
        exp_cnt = exp_cnt + 16'd6;
        write_ctl(8'hA8);
        ext_toggle(6);
        check("R7 R6 mode 101 down", int'(count_out), int'(exp_cnt - 16'd6));
        exp_cnt = exp_cnt - 16'd6;
        write_ctl(8'hC9);
        ext_toggle(6);
        check("R5 external divide by 2", int'(count_out), int'(exp_cnt + 16'd3));
        exp_cnt = exp_cnt + 16'd3;

        // R8: mode 011, direction from pin
        write_ctl(8'h98);
        ext_dir_in = 1'b1;
        run_cycles(4);
        check("R8 dir pin alone no count", int'(count_out), int'(exp_cnt));
        ext_toggle(4);
        check("R8 pin high up", int'(count_out), int'(exp_cnt + 16'd4));
        exp_cnt = exp_cnt + 16'd4;
        ext_dir_in = 1'b0;
        run_cycles(4);
        ext_toggle(2);
        check("R8 pin low down", int'(count_out), int'(exp_cnt - 16'd2));
        exp_cnt = exp_cnt - 16'd2;

        // R9: quadrature, pins now both low
        write_ctl(8'h00);
        run_cycles(4);
        write_ctl(8'hF8);
        quad_move(1'b1, 1'b0);
        check("R9 step 00->10 up", int'(count_out), int'(exp_cnt + 16'd1));
        quad_move(1'b1, 1'b1);
        quad_move(1'b0, 1'b1);
        quad_move(1'b0, 1'b0);
        check("R9 full forward cycle", int'(count_out), int'(exp_cnt + 16'd4));
        exp_cnt = exp_cnt + 16'd4;
        quad_move(1'b0, 1'b1);
        quad_move(1'b1, 1'b1);
        quad_move(1'b1, 1'b0);
        quad_move(1'b0, 1'b0);
        check("R9 full reverse cycle", int'(count_out), int'(exp_cnt - 16'd4));
        exp_cnt = exp_cnt - 16'd4;
        quad_move(1'b1, 1'b1);
        check("R9 double move 00->11 ignored", int'(count_out), int'(exp_cnt));
        quad_move(1'b0, 1'b0);
        check("R9 double move 11->00 ignored", int'(count_out), int'(exp_cnt));
        write_ctl(8'hFB);
        quad_move(1'b1, 1'b0);
        quad_move(1'b1, 1'b1);
        check("R9 prescaler not applied", int'(count_out), int'(exp_cnt + 16'd2));
        exp_cnt = exp_cnt + 16'd2;
        write_ctl(8'hFF);
        quad_move(1'b0, 1'b1);
        quad_move(1'b0, 1'b0);
        check("R10 quad with prescaler 111 holds", int'(count_out), int'(exp_cnt));

        // R3: resume from held value
        write_ctl(8'h40);
        run_cycles(20);
        check("R3 stopped", int'(count_out), int'(exp_cnt));
        write_ctl(8'hC0);
        run_cycles(8);
        check("R3 resumes from held value", int'(count_out), int'(exp_cnt + 16'd2));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule